// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a management-bus master that sends one management write frame for each launch. Software programs it through two 32-bit registers. The control register holds the MDC divisor, a preamble enable and a read-only completion flag. The data register holds the entire 32-bit frame, with its fields at fixed bit positions.

Writing the data register with the start bit set launches a frame. The block drives MDC at a rate set by the divisor. It can first send a preamble of ones, and then sends the 32 data-register bits on MDIO, most significant bit first. When the last bit period ends, the block releases the line and raises the completion flag. Software polls the flag and then writes the control register to clear it.

The divisor and the preamble enable are captured when the frame launches. Control writes made during a frame therefore change only the stored fields, not the frame on the wire. Data-register writes made during a frame are dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both registers read 0, and MDC, MDIO output and MDIO output-enable are all 0.
- R2: Address 0 is the control register. Bits [DIV_W-1:0] hold the divisor, bit 7 the preamble enable and bit 8 the read-only completion flag; all other bits read 0. Any write to address 0 loads the divisor and preamble fields and clears the flag. A launch also clears the flag.
- R3: Address 1 is the data register. A write to address 1 while idle stores the value. If the written bit 30 is 1, the same clock edge launches a frame; if bit 30 is 0, no frame starts.
- R4: With captured divisor D, MDC is 0 at the launch edge and toggles every D+1 clocks, so one bit period is 2(D+1) clocks. MDC stays 0 while idle.
- R5: The frame body is data bits 31 down to 0, one bit per MDC period. Each bit is held from one MDC falling edge to the next; the first bit is held from the launch edge.
- R6: If the preamble enable was 1 at launch, 32 ones are sent before the frame body, for 64 bit periods in all.
- R7: At the clock edge that ends the last bit period, the output enable drops, MDC returns to 0 and the completion flag sets. The flag then stays set until a control write or a launch clears it.
- R8: A data-register write while a frame is in progress is ignored: the stored value and the frame on the wire are unchanged, even if bit 30 is set.
- R9: A control write during a frame updates the control fields read back, but the frame keeps the divisor and preamble setting captured at launch.
- R10: MDIO output-enable is 1 exactly while a frame is in progress, and MDIO output is 0 whenever the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Write address: 0 control, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 1 | Read address: 0 control, 1 data |
| reg_rdata | output | 32 | Read data for reg_raddr, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The assertions assume at most one register write per cycle and a divisor that fits DIV_W. They also assume the fixed bit positions: start bit 30, preamble enable bit 7 and completion flag bit 8. The stimulus drives each write as a single-cycle strobe with fields no wider than the register, so it stays within these assumptions. It sweeps every divisor from 0 to 3 with the preamble on and off, plus the largest divisor. One mid-frame data write and one mid-frame control write are placed well inside a frame and away from its last edge, so the ignore and capture rules are checked without colliding with completion.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned REG_W          = 32;
  localparam int unsigned MAX_DIV_W      = 7;
  localparam int unsigned CTRL_PRE_BIT   = 7;
  localparam int unsigned CTRL_DONE_BIT  = 8;
  localparam int unsigned DATA_START_BIT = 30;
  localparam logic        SEL_CTRL       = 1'b0;
  localparam logic        SEL_DATA       = 1'b1;

  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } shift_state_t;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic             frame_end,
  output logic [DIV_W-1:0] div,
  output logic             pre_en,
  output logic [REG_W-1:0] frame,
  output logic             launch
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_q, pre_d;
  logic             done_q, done_d;
  logic [REG_W-1:0] data_q, data_d;
  logic             ctrl_wr;
  logic             data_wr;
  logic [REG_W-1:0] ctrl_view;

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign data_wr = reg_wr && (reg_addr == SEL_DATA) && !busy;
  assign launch  = data_wr && reg_wdata[DATA_START_BIT];

  always_comb begin
    div_d  = div_q;
    pre_d  = pre_q;
    data_d = data_q;
    done_d = done_q;
    if (ctrl_wr) begin
      div_d = reg_wdata[DIV_W-1:0];
      pre_d = reg_wdata[CTRL_PRE_BIT];
    end
    if (data_wr) begin
      data_d = reg_wdata;
    end
    if (frame_end) begin
      done_d = 1'b1;
    end else if (launch || ctrl_wr) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      div_q  <= div_d;
      pre_q  <= pre_d;
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[DIV_W-1:0]     = div_q;
    ctrl_view[CTRL_PRE_BIT]  = pre_q;
    ctrl_view[CTRL_DONE_BIT] = done_q;
  end

  assign reg_rdata = (reg_raddr == SEL_CTRL) ? ctrl_view : data_q;
  assign div       = div_q;
  assign pre_en    = pre_q;
  assign frame     = data_q;

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done_q); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == SEL_DATA) |=> $stable(data_q)); // R8
  AST_CTRL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !frame_end) |=> !done_q); // R2
endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             mdc_q, mdc_d;
  logic             half_tick;

  assign half_tick = run && (cnt_q == lim_q);
  assign fall_tick = half_tick && mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    mdc_d = mdc_q;
    if (launch) begin
      cnt_d = '0;
      lim_d = div;
      mdc_d = 1'b0;
    end else if (half_tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim_q)); // R4
  AST_IDLE_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !launch) |=> !mdc_q); // R4
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !launch) |=> $stable(lim_q)); // R9
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               pre_en,
  input  logic [FRAME_W-1:0] frame,
  input  logic               fall_tick,
  output logic               busy,
  output logic               mdio_out,
  output logic               frame_end
);
  localparam int unsigned SR_W  = FRAME_W + PRE_LEN;
  localparam int unsigned CNT_W = $clog2(SR_W + 1);

  shift_state_t     state_q, state_d;
  logic [SR_W-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [SR_W-1:0]  load_pre;
  logic [SR_W-1:0]  load_plain;
  logic             use_pre;

  generate
    if (PRE_LEN > 0) begin : g_pre
      assign load_pre   = {{PRE_LEN{1'b1}}, frame};
      assign load_plain = {frame, {PRE_LEN{1'b0}}};
      assign use_pre    = pre_en;
    end else begin : g_nopre
      assign load_pre   = frame;
      assign load_plain = frame;
      assign use_pre    = 1'b0;
    end
  endgenerate

  assign busy      = (state_q == SH_SHIFT);
  assign frame_end = busy && fall_tick && (left_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    left_d  = left_q;
    if (launch) begin
      state_d = SH_SHIFT;
      sr_d    = use_pre ? load_pre : load_plain;
      left_d  = use_pre ? CNT_W'(SR_W) : CNT_W'(FRAME_W);
    end else if (busy && fall_tick) begin
      sr_d   = {sr_q[SR_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
      if (left_q == CNT_W'(1)) begin
        state_d = SH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sr_q    <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      left_q  <= left_d;
    end
  end

  assign mdio_out = busy && sr_q[SR_W-1];

  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0 && left_q <= CNT_W'(SR_W))); // R6
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_tick) |=> $stable(mdio_out)); // R5
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy); // R7
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy); // R8
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe
);
  logic             rst_sync_n;
  logic [DIV_W-1:0] div;
  logic             pre_en;
  logic [REG_W-1:0] frame;
  logic             launch;
  logic             busy;
  logic             frame_end;
  logic             fall_tick;

  mdio_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdio_regs #(.DIV_W(DIV_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .frame_end (frame_end),
    .div       (div),
    .pre_en    (pre_en),
    .frame     (frame),
    .launch    (launch)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .run       (busy),
    .div       (div),
    .mdc       (mdc),
    .fall_tick (fall_tick)
  );

  mdio_shifter #(.FRAME_W(REG_W), .PRE_LEN(PRE_LEN)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .pre_en    (pre_en),
    .frame     (reg_wdata),
    .fall_tick (fall_tick),
    .busy      (busy),
    .mdio_out  (mdio_out),
    .frame_end (frame_end)
  );

  assign mdio_oe = busy;

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mdio_oe |-> (!mdio_out && !mdc)); // R10
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_raddr;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_out;
  logic        mdio_oe;

  int checks;
  int failures;
  bit finished;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic addr, input logic [31:0] val);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = addr;
    reg_wdata = val;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_val(input int d, input bit pre, input bit done);
    logic [31:0] v;
    v      = 32'(d) & 32'h7F;
    v[7]   = pre;
    v[8]   = done;
    return v;
  endfunction

  task automatic run_frame(input int d, input bit pre, input logic [31:0] data,
                           input bit set_ctrl, input bit mid);
    int nbits;
    int total;
    int k;
    logic expbit;
    int fin_d;
    bit fin_pre;
    if (set_ctrl) do_write(1'b0, ctrl_val(d, pre, 1'b0));
    do_write(1'b1, data);
    nbits = pre ? 64 : 32;
    total = nbits * 2 * (d + 1);
    for (int c = 0; c <= total; c++) begin
      reg_raddr = 1'b0;
      #1;
      if (c < total) begin
        k = c / (2 * (d + 1));
        if (pre && k < 32) expbit = 1'b1;
        else expbit = data[31 - (pre ? k - 32 : k)];
        chk("R4 mdc divided clock", {31'b0, mdc}, {31'b0, 1'(((c / (d + 1)) % 2))});
        if (pre && k < 32) chk("R6 preamble bit", {31'b0, mdio_out}, {31'b0, expbit});
        else chk("R5 frame bit", {31'b0, mdio_out}, {31'b0, expbit});
        chk("R10 oe during frame", {31'b0, mdio_oe}, 32'd1);
        chk("R7 flag clear during frame", {31'b0, reg_rdata[8]}, 32'd0);
      end else begin
        chk("R7 flag set at end", {31'b0, reg_rdata[8]}, 32'd1);
        chk("R7 mdc low at end", {31'b0, mdc}, 32'd0);
        chk("R10 oe low at end", {31'b0, mdio_oe}, 32'd0);
        chk("R10 mdio low at end", {31'b0, mdio_out}, 32'd0);
      end
      if (mid && c == 5) begin
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = ~data | 32'h4000_0000;
      end
      if (mid && c == 7) begin
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = ctrl_val(32'h55, !pre, 1'b0);
      end
      @(negedge clk);
      reg_wr = 1'b0;
    end
    repeat (10) @(negedge clk);
    reg_raddr = 1'b0;
    #1;
    chk("R7 flag persists", {31'b0, reg_rdata[8]}, 32'd1);
    chk("R10 idle oe", {31'b0, mdio_oe}, 32'd0);
    fin_d   = mid ? 32'h55 : d;
    fin_pre = mid ? !pre : pre;
    if (mid) chk("R9 control readback after mid write", reg_rdata, ctrl_val(fin_d, fin_pre, 1'b1));
    else chk("R2 control readback", reg_rdata, ctrl_val(fin_d, fin_pre, 1'b1));
    reg_raddr = 1'b1;
    #1;
    if (mid) chk("R8 data unchanged by busy write", reg_rdata, data);
    else chk("R3 data readback", reg_rdata, data);
  endtask

  initial begin
    logic [31:0] pat;
    checks    = 0;
    failures  = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = 1'b0;
    reg_wdata = '0;
    reg_raddr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_raddr = 1'b0; #1;
    chk("R1 control after reset", reg_rdata, 32'd0);
    reg_raddr = 1'b1; #1;
    chk("R1 data after reset", reg_rdata, 32'd0);
    chk("R1 outputs after reset", {29'b0, mdc, mdio_out, mdio_oe}, 32'd0);

    do_write(1'b1, 32'h0000_ABCD);
    for (int i = 0; i < 12; i++) begin
      #1;
      chk("R3 no launch without start bit", {31'b0, mdio_oe}, 32'd0);
      @(negedge clk);
    end
    reg_raddr = 1'b1; #1;
    chk("R3 stored without start bit", reg_rdata, 32'h0000_ABCD);

    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 2; p++) begin
        pat = {2'b01, 2'b01, 5'(d * 7 + 3), 5'(p * 9 + d), 2'b10,
               16'(16'h1234 * (d + 1) ^ (p * 16'hA5C3))};
        run_frame(d, p[0], pat, 1'b1, (d == 1 && p == 0));
      end
    end

    do_write(1'b0, 32'd0);
    reg_raddr = 1'b0; #1;
    chk("R2 control write clears flag", reg_rdata, 32'd0);

    run_frame(2, 1'b0, 32'h5A5A_C3F1, 1'b1, 1'b0);
    run_frame(2, 1'b0, 32'h4F00_00FF, 1'b0, 1'b0);
    run_frame(127, 1'b1, 32'h5086_9ACE, 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule